// File: doc/BRIEF.md
# Arrival-Order Memory Arbiter

This block lets three bus masters share two memory targets: a read-only word array and a synchronous read/write word array. The masters are an instruction fetch port, a data port and a register/system port. Each one presents a request with an address, a write flag, write data and byte-lane enables. It then gets back a one-cycle grant, a one-cycle completion pulse, an error flag and read data.

Requests are served strictly in the order in which they first appeared. The arbiter keeps a small queue of port numbers. It does not use a fixed priority or a rotating pointer. When several ports raise new requests in the same cycle, they enter the queue in port-index order.

The top address bit chooses the target. The remaining address bits form a word index into the chosen array. Each granted access occupies one cycle, so one access can complete every cycle while the queue is not empty.

Top module: `fcfs_mem_arb`

## Requirements
- R1: After reset, `gnt`, `done` and `err` are all zero, `rdata` is zero, and no request is queued.
- R2: Grants are issued in the order in which requests first appeared. A request that appears later is granted after every request that appeared earlier, whatever its port index.
- R3: Requests that first appear in the same cycle are granted in port-index order: port 0 (instruction), then port 1 (data), then port 2 (system).
- R4: Address bit ADDR_W-1 selects the target: 0 selects the read-only array and 1 selects the read/write array. The low ADDR_W-1 bits give the word index, so the same index in the two targets refers to different storage.
- R5: A read of the read-only array at word index i returns 0x0DE00000 + 0x10003*i.
- R6: A write to the read/write array updates only the byte lanes whose enable bit is set. Enable bit b covers data bits 8b+7..8b. A later read of that word returns the merged value.
- R7: A write to the read-only array completes with `err` high on that port in the `done` cycle and leaves the array unchanged. All other accesses complete with `err` low.
- R8: `done` rises on exactly the granted port, one cycle after its grant and for one cycle. For a read, `rdata` holds the read value in that cycle. For a write, `rdata` is zero.
- R9: A port that keeps its request high while waiting is granted exactly once for that request. It can present its next request after its `done`.
- R10: When the queue is empty, a request that first appears in cycle t is granted in cycle t+1 and completes in cycle t+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 3 | Request per port, held high until `done` |
| we | input | 3 | Write flag per port |
| addr | input | 3*ADDR_W | Word address per port; port p uses bits p*ADDR_W upward |
| wdata | input | 3*DATA_W | Write data per port |
| be | input | 3*DATA_W/8 | Byte-lane enables per port |
| gnt | output | 3 | One-hot grant pulse |
| done | output | 3 | One-hot completion pulse |
| err | output | 3 | Error flag for a write to the read-only array, valid with `done` |
| rdata | output | DATA_W | Read data, valid with `done` |

## Verification
A corrupted queue slot or count first shows as a grant to the wrong port. That grant appears within one or two cycles of the damaged entry reaching the head of the queue. A lost pending bit shows as a second grant to a port that is still holding its request. An extra pending bit shows as a port that is never granted.

Routing or lane-merge faults appear in the `done` cycle as a wrong `rdata` value or a wrong `err` flag. A merge fault is seen when the written word is read back.

The directed scenarios build queue backlogs of two and three entries, so ordering faults are visible at the `gnt` outputs.

// File: rtl/fcfs_arb_pkg.sv
package fcfs_arb_pkg;

  localparam int NPORT = 3;

  // Contents of the read-only target, computed per word index.
  function automatic logic [31:0] rom_word(input int unsigned idx);
    return 32'h0DE0_0000 | (idx * 32'h0001_0003);
  endfunction

  // Top address bit set means the read/write target.
  function automatic logic targets_ram(input logic msb);
    return msb;
  endfunction

endpackage

// File: rtl/fcfs_order_q.sv
module fcfs_order_q
  import fcfs_arb_pkg::*;
#(
  parameter int N = NPORT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  output logic [N-1:0] gnt,
  output logic         head_vld,
  output logic [$clog2(N)-1:0] head_id
);
  localparam int ID_W  = $clog2(N);
  localparam int CNT_W = $clog2(N + 1);

  logic [ID_W-1:0]  slot_q [N];
  logic [ID_W-1:0]  slot_n [N];
  logic [CNT_W-1:0] cnt_q, cnt_n, wp;
  logic [N-1:0]     pend_q, pend_n;
  logic [N-1:0]     arrive;

  assign arrive   = req & ~pend_q;
  assign head_vld = (cnt_q != '0);
  assign head_id  = slot_q[0];

  always_comb begin
    gnt = '0;
    if (head_vld) gnt[slot_q[0]] = 1'b1;
  end

  // Pop the head, then append this cycle's arrivals in port-index order.
  always_comb begin
    slot_n = slot_q;
    if (head_vld)
      for (int i = 0; i < N - 1; i++) slot_n[i] = slot_q[i + 1];
    wp = cnt_q - CNT_W'(head_vld);
    for (int p = 0; p < N; p++) begin
      if (arrive[p]) begin
        slot_n[wp] = ID_W'(p);
        wp = wp + CNT_W'(1);
      end
    end
    cnt_n  = wp;
    pend_n = (pend_q | arrive) & ~done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      for (int i = 0; i < N; i++) slot_q[i] <= '0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      slot_q <= slot_n;
    end
  end

  // R2: at most one grant per cycle
  p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2: a grant only goes to a port with a pending request
  p_gnt_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((gnt & pend_q) == gnt));

  // R9: queue never holds more entries than there are pending ports
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= $countones(pend_q));

endmodule

// File: rtl/fcfs_rom.sv
module fcfs_rom
  import fcfs_arb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [$clog2(DEPTH)-1:0] idx,
  output logic [DATA_W-1:0]        rdata
);
  always_ff @(posedge clk) begin
    if (en) rdata <= DATA_W'(rom_word(32'(idx)));
  end
endmodule

// File: rtl/fcfs_ram.sv
module fcfs_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/8-1:0]      be,
  output logic [DATA_W-1:0]        rdata
);
  localparam int BE_W = DATA_W / 8;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] lane_rd;
    always_ff @(posedge clk) begin
      if (en && we && be[b]) lane_mem[idx] <= wdata[8*b +: 8];
      if (en && !we)         lane_rd       <= lane_mem[idx];
    end
    assign rdata[8*b +: 8] = lane_rd;
  end
endmodule

// File: rtl/fcfs_mem_arb.sv
module fcfs_mem_arb
  import fcfs_arb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 1,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        req,
  input  logic [NPORT-1:0]        we,
  input  logic [NPORT*ADDR_W-1:0] addr,
  input  logic [NPORT*DATA_W-1:0] wdata,
  input  logic [NPORT*BE_W-1:0]   be,
  output logic [NPORT-1:0]        gnt,
  output logic [NPORT-1:0]        done,
  output logic [NPORT-1:0]        err,
  output logic [DATA_W-1:0]       rdata
);
  logic                     head_vld;
  logic [$clog2(NPORT)-1:0] head_id;
  logic [ADDR_W-1:0]        h_addr;
  logic [DATA_W-1:0]        h_wdata;
  logic [BE_W-1:0]          h_be;
  logic                     h_we, h_ram;
  logic                     rom_en, ram_en, rom_fault;
  logic [DATA_W-1:0]        rom_rd, ram_rd;
  logic                     sel_q, wr_q;

  fcfs_order_q #(.N(NPORT)) u_q (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .gnt(gnt), .head_vld(head_vld), .head_id(head_id)
  );

  assign h_addr    = addr[head_id*ADDR_W +: ADDR_W];
  assign h_wdata   = wdata[head_id*DATA_W +: DATA_W];
  assign h_be      = be[head_id*BE_W +: BE_W];
  assign h_we      = we[head_id];
  assign h_ram     = targets_ram(h_addr[ADDR_W-1]);
  assign ram_en    = head_vld & h_ram;
  assign rom_en    = head_vld & ~h_ram & ~h_we;
  assign rom_fault = head_vld & ~h_ram & h_we;

  fcfs_rom #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rom (
    .clk(clk), .en(rom_en), .idx(h_addr[IDX_W-1:0]), .rdata(rom_rd)
  );

  fcfs_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .en(ram_en), .we(h_we), .idx(h_addr[IDX_W-1:0]),
    .wdata(h_wdata), .be(h_be), .rdata(ram_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= '0;
      err   <= '0;
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      done  <= gnt;
      err   <= rom_fault ? gnt : '0;
      sel_q <= h_ram;
      wr_q  <= h_we;
    end
  end

  assign rdata = ((done != '0) && !wr_q) ? (sel_q ? ram_rd : rom_rd) : '0;

  // R8: completion follows the grant by exactly one cycle on the same port
  p_done_follows_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |=> (done == $past(gnt)));

  // R8: no completion without a grant in the previous cycle
  p_no_stray_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> (done == '0));

  // R7: a write aimed at the read-only target reports an error
  p_rom_write_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_fault |=> (err == done && err != '0));

  // R7: other accesses never report an error
  p_err_only_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_fault |=> (err == '0));

  // R9: a granted port still holds its request
  p_gnt_held_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: tb/fcfs_mem_arb_test.sv
module fcfs_mem_arb_test;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    req_i = '0, we_i = '0;
  logic [3*AW-1:0] addr_i = '0;
  logic [3*DW-1:0] wdata_i = '0;
  logic [3*BW-1:0] be_i = '0;
  logic [2:0]    gnt_o, done_o, err_o;
  logic [DW-1:0] rdata_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [AW-1:0] t_addr [3];
  logic          t_we   [3];
  logic [DW-1:0] t_wd   [3];
  logic [BW-1:0] t_be   [3];
  int            t_start[3];
  int g_cyc[3], d_cyc[3], g_cnt[3], ord[3];
  int nord;
  logic [DW-1:0] res_rd [3];
  logic          res_er [3];

  fcfs_mem_arb uut (
    .clk(clk), .rst_n(rst_n), .req(req_i), .we(we_i), .addr(addr_i),
    .wdata(wdata_i), .be(be_i), .gnt(gnt_o), .done(done_o), .err(err_o),
    .rdata(rdata_o)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] exp_rom(input int i);
    return 32'h0DE0_0000 + (i << 16) + 3 * i;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setup(input int p, input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [BW-1:0] b, input int st);
    t_we[p] = w; t_addr[p] = a; t_wd[p] = d; t_be[p] = b; t_start[p] = st;
  endtask

  task automatic run_batch(input logic [2:0] mask);
    logic [2:0] left;
    left = mask;
    nord = 0;
    for (int p = 0; p < 3; p++) begin
      g_cyc[p] = -1; d_cyc[p] = -1; g_cnt[p] = 0; ord[p] = -1;
      res_rd[p] = 'x; res_er[p] = 1'bx;
    end
    for (int k = 0; k < 30 && left != 0; k++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (gnt_o[p]) begin
          g_cnt[p]++; g_cyc[p] = k;
          if (nord < 3) ord[nord] = p;
          nord++;
        end
        if (done_o[p]) begin
          d_cyc[p] = k; res_rd[p] = rdata_o; res_er[p] = err_o[p];
          req_i[p] = 1'b0; left[p] = 1'b0;
        end
      end
      for (int p = 0; p < 3; p++) begin
        if (mask[p] && t_start[p] == k) begin
          req_i[p] = 1'b1; we_i[p] = t_we[p];
          addr_i[p*AW +: AW] = t_addr[p];
          wdata_i[p*DW +: DW] = t_wd[p];
          be_i[p*BW +: BW] = t_be[p];
        end
      end
    end
    @(negedge clk);
    check("R8 no grant or done after batch", {29'd0, gnt_o | done_o}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 gnt after reset", {29'd0, gnt_o}, 32'd0);
    check("R1 done after reset", {29'd0, done_o}, 32'd0);
    check("R1 err after reset", {29'd0, err_o}, 32'd0);
    check("R1 rdata after reset", rdata_o, 32'd0);
  endtask

  task automatic t_rom_read;
    setup(0, 1'b0, 5'h05, '0, 4'hF, 0);
    run_batch(3'b001);
    check("R5 rom word 5", res_rd[0], exp_rom(5));
    check("R10 grant cycle", g_cyc[0], 1);
    check("R10 done cycle", d_cyc[0], 2);
    check("R7 no err on read", {31'd0, res_er[0]}, 32'd0);
  endtask

  task automatic t_ram_rw;
    setup(1, 1'b1, 5'h13, 32'hAABBCCDD, 4'hF, 0);
    run_batch(3'b010);
    check("R8 rdata zero on write", res_rd[1], 32'd0);
    setup(2, 1'b0, 5'h13, '0, 4'hF, 0);
    run_batch(3'b100);
    check("R6 ram readback", res_rd[2], 32'hAABBCCDD);
  endtask

  task automatic t_byte_lanes;
    setup(0, 1'b1, 5'h13, 32'h11223344, 4'b0101, 0);
    run_batch(3'b001);
    setup(0, 1'b0, 5'h13, '0, 4'h0, 0);
    run_batch(3'b001);
    check("R6 lane merge", res_rd[0], 32'hAA22CC44);
  endtask

  task automatic t_routing;
    setup(1, 1'b1, 5'h15, 32'h5A5A0001, 4'hF, 0);
    run_batch(3'b010);
    setup(0, 1'b0, 5'h05, '0, 4'hF, 0);
    setup(2, 1'b0, 5'h15, '0, 4'hF, 0);
    run_batch(3'b101);
    check("R4 rom index 5 untouched", res_rd[0], exp_rom(5));
    check("R4 ram index 5", res_rd[2], 32'h5A5A0001);
  endtask

  task automatic t_tie;
    setup(0, 1'b0, 5'h01, '0, 4'hF, 0);
    setup(1, 1'b0, 5'h02, '0, 4'hF, 0);
    setup(2, 1'b0, 5'h03, '0, 4'hF, 0);
    run_batch(3'b111);
    check("R3 first", ord[0], 0);
    check("R3 second", ord[1], 1);
    check("R3 third", ord[2], 2);
    check("R3 last grant cycle", g_cyc[2], 3);
    check("R8 last done cycle", d_cyc[2], 4);
    check("R5 rom word 3 via port 2", res_rd[2], exp_rom(3));
    check("R9 single grant port 2", g_cnt[2], 1);
    check("R9 single grant port 1", g_cnt[1], 1);
  endtask

  task automatic t_arrival;
    setup(1, 1'b0, 5'h04, '0, 4'hF, 0);
    setup(2, 1'b0, 5'h06, '0, 4'hF, 0);
    setup(0, 1'b0, 5'h08, '0, 4'hF, 1);
    run_batch(3'b111);
    check("R2 first", ord[0], 1);
    check("R2 second", ord[1], 2);
    check("R2 late port 0 last", ord[2], 0);
    check("R2 port 0 grant cycle", g_cyc[0], 3);
    check("R9 single grant port 0", g_cnt[0], 1);
    check("R5 rom word 8", res_rd[0], exp_rom(8));
  endtask

  task automatic t_rom_write;
    setup(1, 1'b1, 5'h07, 32'hFFFFFFFF, 4'hF, 0);
    run_batch(3'b010);
    check("R7 err on rom write", {31'd0, res_er[1]}, 32'd1);
    check("R7 done cycle", d_cyc[1], 2);
    setup(1, 1'b0, 5'h07, '0, 4'hF, 0);
    run_batch(3'b010);
    check("R7 rom unchanged", res_rd[1], exp_rom(7));
    check("R7 no err on read", {31'd0, res_er[1]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom_read();
    t_ram_rw();
    t_byte_lanes();
    t_routing();
    t_tie();
    t_arrival();
    t_rom_write();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule